// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The memory has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable, and it shares one data bus for both directions. The host issues single read or write requests through a valid/ready handshake. The controller turns each request into a select/strobe sequence that meets the memory's minimum timing, then reports completion with a one-cycle done pulse. On a read, the captured byte comes out on the same cycle as the pulse.

Every phase length is a whole number of clock cycles. Each one is computed from a clock-period parameter in nanoseconds and from the memory's timing figures. An access runs through the phases setup, strobe and hold, then a done cycle, and the controller returns to idle. The data bus is split at the block's edge into an output value, an output-enable and an input value. The pad or tristate buffer joins them into the shared bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and on the first cycle after it, both selects are inactive (mem_cs1_n=1, mem_cs2=0), mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rsp_done=0.
- R2: A request is accepted only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the done cycle is over. A req_valid presented while busy starts nothing and writes nothing.
- R3: During a write, both selects stay active (mem_cs1_n=0, mem_cs2=1) and mem_oe_n stays 1 for as long as mem_we_n is 0. The write ends by raising mem_we_n while both selects are still active. The selects go inactive one cycle later.
- R4: At the end of every write, all of these hold: mem_we_n has been low for at least 55 ns, the address and selects have been stable for at least 65 ns, the data has been driven and stable for at least 30 ns, and the whole select period is at least 70 ns.
- R5: mem_dq_oe is 1 only while mem_we_n is 0 and mem_oe_n is 1. mem_oe_n has been 1 for at least 25 ns before mem_dq_oe rises.
- R6: During a read, mem_we_n stays 1 and mem_oe_n is 0 together with both selects active. The byte on mem_dq_in is registered on the last cycle of the window. By that edge the address and selects have been stable for at least 70 ns and mem_oe_n has been low for at least 35 ns.
- R7: rsp_done is high for exactly one cycle per access, with both selects already inactive. For a read, rsp_rdata holds the captured byte in that cycle. rsp_done rises SETUP+STROBE+1 clock edges after the accepting edge.
- R8: mem_addr equals the accepted req_addr and does not change while the selects are active.
- R9: Each phase length is ceil(t/CLK_NS) cycles with a minimum of 1:
  - write SETUP = ceil(25/T);
  - write STROBE = max(ceil(55/T), ceil(30/T), ceil(65/T) - SETUP, ceil(70/T) - SETUP - 1);
  - read SETUP = 1;
  - read STROBE = max(ceil(70/T) - 1, ceil(35/T) - 1).
  
  With the default of T = 4 these give a write strobe of 14 cycles, a read output-enable window of 18 cycles, and done after 22 edges for a write and 19 edges for a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 8 | Data returned from the memory bus |

## Verification
A wrong phase counter or state register would show on the memory pins within the same access. Examples are a write strobe that is one cycle short, a select that drops before the strobe, or the data drivers switched on while the output enable is low. The memory model checks each of these at the cycle the violation occurs. Early read capture, or an address that drifts inside the window, makes the model return a poisoned byte. That byte then appears on rsp_rdata at the done pulse of that very access. Counting errors in the state sequence move the done pulse away from its computed edge, or leave req_ready low, so the first access after the fault already reports it.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } ctl_state_e;

  // whole cycles covering t_ns, never below one
  function automatic int ceil_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= len - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CW       = 5,
  parameter int W_SETUP  = 7,
  parameter int W_STROBE = 14,
  parameter int R_SETUP  = 1,
  parameter int R_STROBE = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          tmr_zero,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_len,
  output logic          cap
);
  ctl_state_e state;
  logic       wr_q;

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = CW'(W_SETUP);
    case (state)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        tmr_len  = req_write ? CW'(W_SETUP) : CW'(R_SETUP);
      end
      ST_SETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_len  = wr_q ? CW'(W_STROBE) : CW'(R_STROBE);
      end
      default: ;
    endcase
  end

  assign cap       = (state == ST_STROBE) && tmr_zero && !wr_q;
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_q       <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_cs1_n  <= 1'b1;
      mem_cs2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state      <= ST_SETUP;
          wr_q       <= req_write;
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
          mem_cs1_n  <= 1'b0;
          mem_cs2    <= 1'b1;
          mem_oe_n   <= req_write;
        end
        ST_SETUP: if (tmr_zero) begin
          state <= ST_STROBE;
          if (wr_q) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
          end
        end
        ST_STROBE: if (tmr_zero) begin
          state     <= ST_HOLD;
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          mem_oe_n  <= 1'b1;
        end
        ST_HOLD: begin
          state     <= ST_DONE;
          mem_cs1_n <= 1'b1;
          mem_cs2   <= 1'b0;
          rsp_done  <= 1'b1;
        end
        default: begin
          state    <= ST_IDLE;
          rsp_done <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int T_CYC   = 70,
  parameter int T_ACC   = 70,
  parameter int T_OEACC = 35,
  parameter int T_WPW   = 55,
  parameter int T_AEND  = 65,
  parameter int T_DSU   = 30,
  parameter int T_OHZ   = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int WS = ceil_cyc(T_OHZ, CLK_NS);
  localparam int WB = imax(imax(ceil_cyc(T_WPW, CLK_NS), ceil_cyc(T_DSU, CLK_NS)),
                           imax(ceil_cyc(T_AEND, CLK_NS) - WS,
                                ceil_cyc(T_CYC, CLK_NS) - WS - 1));
  localparam int RS = 1;
  localparam int RB = imax(1, imax(imax(ceil_cyc(T_ACC, CLK_NS), ceil_cyc(T_CYC, CLK_NS)) - RS,
                                   ceil_cyc(T_OEACC, CLK_NS) - RS));
  localparam int MAXLEN = imax(imax(WS, WB), imax(RS, RB));
  localparam int CW = $clog2(MAXLEN + 1);

  logic          tmr_load, tmr_zero, cap;
  logic [CW-1:0] tmr_len;

  sram_ctl_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .W_SETUP(WS), .W_STROBE(WB), .R_SETUP(RS), .R_STROBE(RB)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .tmr_zero(tmr_zero),
    .req_ready(req_ready), .rsp_done(rsp_done),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .tmr_load(tmr_load), .tmr_len(tmr_len), .cap(cap)
  );

  sram_ctl_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .zero(tmr_zero)
  );

  sram_ctl_rdcap #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cap(cap), .din(mem_dq_in), .dout(rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs1_n,
  input logic          mem_cs2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  logic sel;
  assign sel = !mem_cs1_n && mem_cs2;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R2
  AST_STAY_BUSY: assert property (@(posedge clk) disable iff (rst) (!req_ready && !rsp_done) |=> !req_ready); // R2
  AST_WE_INSIDE_SEL: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (sel && mem_oe_n)); // R3
  AST_WE_ENDS_FIRST: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> sel); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R5
  AST_READ_SHAPE: assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> (mem_we_n && sel)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R7
  AST_DONE_DESEL: assert property (@(posedge clk) disable iff (rst) rsp_done |-> !sel); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) (sel && $past(sel)) |-> $stable(mem_addr)); // R8
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
  .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
  localparam int CK = 4;

  function automatic int cyc(input int t);
    int c;
    c = (t + CK - 1) / CK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from R9
  localparam int E_WS  = cyc(25);
  localparam int E_WB  = mx(mx(cyc(55), cyc(30)), mx(cyc(65) - E_WS, cyc(70) - E_WS - 1));
  localparam int E_RB  = mx(cyc(70) - 1, cyc(35) - 1);
  localparam int E_WLAT = E_WS + E_WB + 1;
  localparam int E_RLAT = 1 + E_RB + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in;
  logic [16:0] mem_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_ctl #(.CLK_NS(CK)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model, evaluated mid-cycle
  logic [7:0] m_data [256];
  logic [8:0] m_tag  [256];
  bit         m_vld  [256];
  int sel_cnt, oe_lo, oe_hi, we_lo, d_cnt;
  int last_we, last_oe;
  bit sel_p, we_p, oe_p, dqe_p;
  logic [16:0] addr_p;
  logic [7:0]  d_p;

  always @(negedge clk) begin
    bit sel;
    if (rst) begin
      sel_cnt = 0; oe_lo = 0; oe_hi = 100; we_lo = 0; d_cnt = 0;
      sel_p = 0; we_p = 1; oe_p = 1; dqe_p = 0; addr_p = '0; d_p = '0;
      last_we = 0; last_oe = 0;
      for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;
      mem_dq_in = 'z;
    end else begin
      sel = !mem_cs1_n && mem_cs2;
      if (mem_dq_oe) chk(mem_oe_n && !mem_we_n, "R5 drive window", mem_oe_n, 1);
      if (mem_dq_oe && !dqe_p) chk(oe_hi * CK >= 25, "R5 oe high before drive ns", oe_hi * CK, 25);
      if (sel && sel_p && mem_addr != addr_p) chk(0, "R8 address moved", mem_addr, addr_p);
      if (!mem_we_n && !sel) chk(0, "R3 select left during strobe", sel, 1);
      if (mem_we_n && !we_p) begin
        chk(sel, "R3 strobe released before selects", sel, 1);
        chk(we_lo * CK >= 55, "R4 strobe width ns", we_lo * CK, 55);
        chk(sel_cnt * CK >= 65, "R4 addr/select to end ns", sel_cnt * CK, 65);
        chk(d_cnt * CK >= 30, "R4 data setup ns", d_cnt * CK, 30);
        chk(we_lo == E_WB, "R9 strobe cycles", we_lo, E_WB);
        last_we = we_lo;
        m_data[mem_addr[7:0]] = d_p;
        m_tag[mem_addr[7:0]]  = mem_addr[16:8];
        m_vld[mem_addr[7:0]]  = 1'b1;
      end
      if (sel_p && !sel) chk(sel_cnt * CK >= 70, "R4 select period ns", sel_cnt * CK, 70);
      if (mem_oe_n && !oe_p) begin
        chk(oe_lo == 1 + E_RB, "R9 read window cycles", oe_lo, 1 + E_RB);
        last_oe = oe_lo;
      end
      // counters including this cycle
      sel_cnt = sel ? ((sel_p && mem_addr == addr_p) ? sel_cnt + 1 : 1) : 0;
      oe_lo   = !mem_oe_n ? oe_lo + 1 : 0;
      oe_hi   = mem_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : 100) : 0;
      we_lo   = !mem_we_n ? we_lo + 1 : 0;
      d_cnt   = mem_dq_oe ? ((dqe_p && mem_dq_out == d_p) ? d_cnt + 1 : 1) : 0;
      if (sel && !mem_oe_n && mem_we_n) begin
        if (sel_cnt * CK >= 70 && oe_lo * CK >= 35 && m_vld[mem_addr[7:0]] &&
            m_tag[mem_addr[7:0]] == mem_addr[16:8])
          mem_dq_in = m_data[mem_addr[7:0]];
        else
          mem_dq_in = ~m_data[mem_addr[7:0]] ^ 8'h3c;
      end else mem_dq_in = 'z;
      sel_p = sel; we_p = mem_we_n; oe_p = mem_oe_n; dqe_p = mem_dq_oe;
      addr_p = mem_addr; d_p = mem_dq_out;
    end
  end

  function automatic logic [16:0] sw_addr(input int i);
    logic [8:0] t;
    t = 9'((i * 37 + 5) % 512);
    return {t, 8'(i)};
  endfunction
  function automatic logic [7:0] sw_data(input int i);
    return 8'(((i * 13 + 7) % 256) ^ ((i / 3) % 256));
  endfunction

  // one access; if decoy, req_valid stays high with a different request while busy
  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input bit decoy, output logic [7:0] rd);
    int n;
    bit busy_ok;
    @(negedge clk);
    chk(req_ready, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (decoy) begin
      req_write = 1'b1; req_addr = a ^ 17'h15555; req_wdata = ~d;
    end else req_valid = 1'b0;
    chk(mem_addr == a, "R8 address driven", mem_addr, a);
    n = 0; busy_ok = 1'b1;
    while (!rsp_done && n < 100) begin
      if (req_ready) busy_ok = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(busy_ok && !req_ready, "R2 ready low while busy", req_ready, 0);
    chk(n == (wr ? E_WLAT : E_RLAT), "R7 done latency", n, wr ? E_WLAT : E_RLAT);
    rd = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_done, "R7 done one cycle", rsp_done, 0);
  endtask

  initial begin
    logic [7:0] rd, exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_cs1_n && !mem_cs2, "R1 selects inactive in reset", {mem_cs1_n, mem_cs2}, 2);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle in reset",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 6);
    chk(req_ready && !rsp_done, "R1 handshake idle in reset", {req_ready, rsp_done}, 2);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
        "R1 idle after reset", 0, 0);
    // write sweep
    for (int i = 0; i < 256; i++) access(1'b1, sw_addr(i), sw_data(i), 1'b0, rd);
    // decoy write to entry 10 while a second request waits (R2)
    access(1'b1, sw_addr(10), 8'ha5, 1'b1, rd);
    // read back in reverse order
    for (int i = 255; i >= 0; i--) begin
      exp = (i == 10) ? 8'ha5 : sw_data(i);
      access(1'b0, sw_addr(i), 8'h00, 1'b0, rd);
      chk(rd === exp, (i == (10 ^ 8'h55)) ? "R2 decoy left slot untouched" : "R6 read data",
          int'(rd), int'(exp));
    end
    // back-to-back read of the same word (R6) and last write/read window (R9)
    access(1'b0, sw_addr(200), 8'h00, 1'b0, rd);
    chk(rd === sw_data(200), "R6 repeated read", int'(rd), int'(sw_data(200)));
    chk(last_we == E_WB, "R9 last strobe cycles", last_we, E_WB);
    chk(last_oe == 1 + E_RB, "R9 last read window", last_oe, 1 + E_RB);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule